// File: doc/BRIEF.md
# Clustered Dispatch Chain Steering

This block decides where a dispatching instruction goes in a core whose scheduler is split into several issue-queue clusters. An upstream classifier has already worked out whether the instruction starts a new dependence chain, which of its two source operands follow a chain, the chain numbers of those operands, the clusters that produce them, and how many operands are still pending. From that summary, the live status of every cluster, and a policy selector, the block picks a cluster and, when the instruction heads a chain, a chain number. When it falls back to a cluster other than the preferred one, it can force the instruction to become a chain head.

The block owns the pool of free chain numbers. A chain number is taken when a head instruction is accepted. It comes back through a release strobe. In split-pool modes, chain j belongs to cluster j mod NCLUS.

The request side is a valid/ready stream. `req_ready` depends only on the status and classifier inputs and never on `req_valid`, so no combinational loop can form. `req_ready` is low whenever the instruction cannot be placed. The upstream stage then holds its request unchanged, and nothing inside the block changes. The decision outputs are meaningful while `stall` is low. A transfer (`req_valid` and `req_ready` both high at a clock edge) commits the chain allocation.

Top module: `chain_steer`

## Requirements
- R1: After reset every chain number is free. A head request in single-cluster mode is then offered chain 0, with `req_ready` high.
- R2: When `chained_cnt` is 2 and the two source clusters differ, a cluster is eligible if its free-slot count is non-zero and its `cap_hit` bit is clear. If both are eligible, the producing cluster is the one with more free slots, and operand 0's cluster wins a tie. If only one is eligible, that one is the producing cluster. If neither is eligible, operand 1's cluster is the producing cluster. When `chained_cnt` is 2 and the two source clusters are equal, that cluster is the producing cluster.
- R3: When `chained_cnt` is 1 or `pending_cnt` is non-zero (and R2 does not apply), the producing cluster is the source cluster of operand `last_op`. When nothing is pending, the producing cluster is the cluster with the most free slots, with the lowest index winning a tie.
- R4: With policy 0 (one-to-one), the block places the instruction only in `req_cl`, and the chain is the lowest-numbered free chain. If `req_cl` cannot accept the instruction, the block stalls.
- R5: With policy 1 (split pool), an acceptable producing cluster is chosen, and its chain is the lowest free chain j with j mod NCLUS equal to that cluster.
- R6: With policy 1 or 3, if the producing cluster cannot accept the instruction, the block falls back to the least-full cluster, found as in R3. The fallback requires that cluster to differ from the producing cluster and to accept a head instruction. The fallback forces `head_out` high. It also clears `chained_out[i]` for every chained operand whose `chain_map` bit at index cluster*NCHAIN + chain number is 0. Otherwise the block stalls.
- R7: With policy 2 (split pool, no fallback), the block uses only the producing cluster and its pool, and stalls if that cluster cannot accept the instruction.
- R8: With policy 3 (shared pool), the cluster choice follows R5 and R6, but the chain is the lowest free chain of all.
- R9: A cluster accepts an instruction only if its free-slot count is non-zero and its `cap_hit` bit is clear. For a head instruction, a chain must also be available: from the cluster's own pool for policies 1 and 2, or from the shared pool for policies 0 and 3.
- R10: With `wires_en` low, the cluster is `req_cl`, and a head instruction takes the lowest free chain. The block stalls only when a head instruction finds no free chain.
- R11: An accepted head transfer marks its chain busy from the next cycle on, so the chain is not offered again. A release strobe makes `rel_chain` free again from the next cycle.
- R12: `req_ready` is the inverse of `stall`. A non-head result reports chain 0. `chained_out` never sets a flag that `op_chained` leaves clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Dispatch request present |
| req_ready | output | 1 | Request can be placed this cycle |
| req_head | input | 1 | Classifier marks the instruction as a chain head |
| req_cl | input | CW | Originally requested cluster |
| op_chained | input | 2 | Per-operand chained flags |
| op_chain | input | 2*IW | Chain numbers, operand 0 in the low bits |
| op_src | input | 2*CW | Producing cluster per operand, operand 0 in the low bits |
| last_op | input | 1 | Index of the operand predicted to arrive last |
| pending_cnt | input | 2 | Operands not yet available |
| chained_cnt | input | 2 | Operands following a chain |
| policy | input | 2 | 0 one-to-one, 1 split pool, 2 split pool without fallback, 3 shared pool |
| wires_en | input | 1 | Multi-cluster chain steering enabled |
| slots | input | NCLUS*SW | Free-slot count per cluster, cluster 0 in the low bits |
| cap_hit | input | NCLUS | Per-cluster thread cap reached |
| chain_map | input | NCLUS*NCHAIN | Bit c*NCHAIN+k set when chain k is visible in cluster c |
| rel_valid | input | 1 | Release strobe |
| rel_chain | input | IW | Chain number being released |
| sel_cl | output | CW | Chosen cluster |
| sel_chain | output | IW | Allocated chain (0 when not a head) |
| head_out | output | 1 | Instruction heads a chain (classifier or forced) |
| chained_out | output | 2 | Chained flags after fallback unchaining |
| stall | output | 1 | Instruction cannot be placed |

## Verification
The assertions assume a consistent classifier. `chained_cnt` equals the number of set `op_chained` bits, `pending_cnt` is at least `chained_cnt`, and two chained operands never share a chain number. They also assume that a release only names a chain that is currently busy. The bench builds every random vector to meet these rules. It derives the counts from the flags it draws and moves one chain number when the two collide. It releases a chain only when its own model of the pool shows that chain as taken. Random request validity and releases keep the pools alternating between scarce and plentiful, so the stall and fallback paths occur often.

// File: rtl/steer_pkg.sv
package steer_pkg;
  typedef enum logic [1:0] {
    POL_ONE   = 2'd0,
    POL_SPLIT = 2'd1,
    POL_HOLD  = 2'd2,
    POL_SHARE = 2'd3
  } steer_pol_e;
endpackage

// File: rtl/steer_lowest.sv
module steer_lowest #(
  parameter int W  = 32,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  mask,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/steer_argmax.sv
module steer_argmax #(
  parameter int N  = 4,
  parameter int SW = 4,
  localparam int CW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N*SW-1:0] slots,
  output logic [CW-1:0]   best
);
  always_comb begin
    logic [SW-1:0] top;
    best = '0;
    top  = slots[SW-1:0];
    for (int c = 1; c < N; c++) begin
      if (slots[c*SW +: SW] > top) begin
        top  = slots[c*SW +: SW];
        best = CW'(c);
      end
    end
  end
endmodule

// File: rtl/steer_chain_pool.sv
module steer_chain_pool #(
  parameter int NCHAIN = 32,
  localparam int IW = $clog2(NCHAIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [IW-1:0]     alloc_id,
  input  logic              rel_en,
  input  logic [IW-1:0]     rel_id,
  output logic [NCHAIN-1:0] free_q
);
  logic [NCHAIN-1:0] take, give;

  always_comb begin
    take = '0;
    give = '0;
    if (alloc_en) take[alloc_id] = 1'b1;
    if (rel_en)   give[rel_id]   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) free_q <= '1;
    else        free_q <= (free_q & ~take) | give;
  end

  // R11: a taken chain reads busy on the following cycle
  a_r11_alloc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en && !(rel_en && rel_id == alloc_id) |=> !free_q[$past(alloc_id)]);

  // R11: a released chain reads free on the following cycle
  a_r11_release_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |=> free_q[$past(rel_id)]);
endmodule

// File: rtl/chain_steer.sv
module chain_steer
  import steer_pkg::*;
#(
  parameter int NCLUS  = 4,
  parameter int NCHAIN = 32,
  parameter int SW     = 4,
  localparam int CW = $clog2(NCLUS),
  localparam int IW = $clog2(NCHAIN)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_head,
  input  logic [CW-1:0]           req_cl,
  input  logic [1:0]              op_chained,
  input  logic [2*IW-1:0]         op_chain,
  input  logic [2*CW-1:0]         op_src,
  input  logic                    last_op,
  input  logic [1:0]              pending_cnt,
  input  logic [1:0]              chained_cnt,
  input  logic [1:0]              policy,
  input  logic                    wires_en,
  input  logic [NCLUS*SW-1:0]     slots,
  input  logic [NCLUS-1:0]        cap_hit,
  input  logic [NCLUS*NCHAIN-1:0] chain_map,
  input  logic                    rel_valid,
  input  logic [IW-1:0]           rel_chain,
  output logic [CW-1:0]           sel_cl,
  output logic [IW-1:0]           sel_chain,
  output logic                    head_out,
  output logic [1:0]              chained_out,
  output logic                    stall
);
  steer_pol_e pol;
  assign pol = steer_pol_e'(policy);

  logic [NCHAIN-1:0] free_q;
  logic [SW-1:0]     slot_a  [NCLUS];
  logic [NCHAIN-1:0] pmask   [NCLUS];
  logic              pool_hit[NCLUS];
  logic [IW-1:0]     pool_id [NCLUS];
  logic [NCLUS-1:0]  elig, avail;
  logic              glob_hit;
  logic [IW-1:0]     glob_id;
  logic [CW-1:0]     lf_cl, prod_cl, src0, src1;
  logic              split_mode, fb;
  logic [IW-1:0]     pick_id;

  // Per-cluster status and split chain pools (chain j lives in cluster j mod NCLUS)
  for (genvar c = 0; c < NCLUS; c++) begin : g_clus
    assign slot_a[c] = slots[c*SW +: SW];
    assign elig[c]   = (slot_a[c] != '0) && !cap_hit[c];
    for (genvar j = 0; j < NCHAIN; j++) begin : g_pm
      assign pmask[c][j] = ((j % NCLUS) == c) ? free_q[j] : 1'b0;
    end
    steer_lowest #(.W(NCHAIN)) u_pool_pick (
      .mask(pmask[c]), .hit(pool_hit[c]), .idx(pool_id[c]));
    assign avail[c] = split_mode ? pool_hit[c] : glob_hit;
  end

  steer_lowest #(.W(NCHAIN)) u_glob_pick (
    .mask(free_q), .hit(glob_hit), .idx(glob_id));

  steer_argmax #(.N(NCLUS), .SW(SW)) u_least_full (
    .slots(slots), .best(lf_cl));

  assign split_mode = wires_en && (pol == POL_SPLIT || pol == POL_HOLD);
  assign src0 = op_src[CW-1:0];
  assign src1 = op_src[2*CW-1:CW];

  // Producing-cluster affinity
  always_comb begin
    if (chained_cnt == 2'd2) begin
      if (src0 == src1)                prod_cl = src0;
      else if (elig[src0] && elig[src1])
        prod_cl = (slot_a[src1] > slot_a[src0]) ? src1 : src0;
      else if (elig[src0])             prod_cl = src0;
      else                             prod_cl = src1;
    end else if (chained_cnt == 2'd1 || pending_cnt != 2'd0) begin
      prod_cl = last_op ? src1 : src0;
    end else begin
      prod_cl = lf_cl;
    end
  end

  // Policy decision
  always_comb begin
    logic ok_prod, ok_lf;
    ok_prod = elig[prod_cl] && (!req_head || avail[prod_cl]);
    ok_lf   = elig[lf_cl] && avail[lf_cl];
    sel_cl  = req_cl;
    fb      = 1'b0;
    stall   = 1'b0;
    if (!wires_en) begin
      stall = req_head && !glob_hit;
    end else begin
      unique case (pol)
        POL_ONE: begin
          if (!(elig[req_cl] && (!req_head || avail[req_cl]))) stall = 1'b1;
        end
        POL_HOLD: begin
          sel_cl = prod_cl;
          if (!ok_prod) stall = 1'b1;
        end
        default: begin
          sel_cl = prod_cl;
          if (!ok_prod) begin
            if (lf_cl != prod_cl && ok_lf) begin
              sel_cl = lf_cl;
              fb     = 1'b1;
            end else begin
              stall = 1'b1;
            end
          end
        end
      endcase
    end
  end

  assign head_out  = req_head | fb;
  assign pick_id   = split_mode ? pool_id[sel_cl] : glob_id;
  assign sel_chain = head_out ? pick_id : '0;
  assign req_ready = !stall;

  // Fallback unchains operands whose chain the new cluster cannot see
  always_comb begin
    for (int i = 0; i < 2; i++) begin
      logic [IW-1:0] ch;
      ch = op_chain[i*IW +: IW];
      chained_out[i] = op_chained[i] &&
        !(fb && !chain_map[int'(sel_cl)*NCHAIN + int'(ch)]);
    end
  end

  steer_chain_pool #(.NCHAIN(NCHAIN)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(req_valid && !stall && head_out), .alloc_id(sel_chain),
    .rel_en(rel_valid), .rel_id(rel_chain),
    .free_q(free_q));

  // R9: the chosen cluster has room and is under its cap
  a_r9_cluster_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    wires_en && !stall |-> (slot_a[sel_cl] != '0) && !cap_hit[sel_cl]);

  // R4: one-to-one never leaves the requested cluster
  a_r4_stays_home: assert property (@(posedge clk) disable iff (!rst_n)
    wires_en && pol == POL_ONE && !stall |-> sel_cl == req_cl);

  // R5: split pools hand out chains owned by the chosen cluster
  a_r5_pool_owner: assert property (@(posedge clk) disable iff (!rst_n)
    split_mode && head_out && !stall |-> (int'(sel_chain) % NCLUS) == int'(sel_cl));

  // R11: an offered chain is currently free
  a_r11_offer_is_free: assert property (@(posedge clk) disable iff (!rst_n)
    head_out && !stall |-> free_q[sel_chain]);

  // R6: leaving the producing cluster makes a head
  a_r6_fallback_heads: assert property (@(posedge clk) disable iff (!rst_n)
    wires_en && (pol == POL_SPLIT || pol == POL_SHARE) && !stall && sel_cl != prod_cl
    |-> head_out);

  // R12: flags are only ever dropped
  a_r12_flags_drop_only: assert property (@(posedge clk) disable iff (!rst_n)
    (chained_out & ~op_chained) == 2'b00);
endmodule

// File: tb/chain_steer_test.sv
`timescale 1ns/1ps
module chain_steer_test;
  localparam int NCL = 4;
  localparam int NCH = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_head, last_op, wires_en, rel_valid;
  logic [1:0]  req_cl, op_chained, pending_cnt, chained_cnt, policy, sel_cl, chained_out;
  logic [9:0]  op_chain;
  logic [3:0]  op_src, cap_hit;
  logic [15:0] slots;
  logic [127:0] chain_map;
  logic [4:0]  rel_chain, sel_chain;
  logic        head_out, stall;

  chain_steer uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_head(req_head), .req_cl(req_cl), .op_chained(op_chained), .op_chain(op_chain),
    .op_src(op_src), .last_op(last_op), .pending_cnt(pending_cnt), .chained_cnt(chained_cnt),
    .policy(policy), .wires_en(wires_en), .slots(slots), .cap_hit(cap_hit),
    .chain_map(chain_map), .rel_valid(rel_valid), .rel_chain(rel_chain),
    .sel_cl(sel_cl), .sel_chain(sel_chain), .head_out(head_out),
    .chained_out(chained_out), .stall(stall));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [NCH-1:0] m_free;
  logic [31:0] seed = 32'h1234_5678;

  logic       e_stall, e_head, e_fb;
  logic [1:0] e_cl, e_chd;
  logic [4:0] e_chain;

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed ^ (seed >> 15);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 0; req_head = 0; req_cl = 0; op_chained = 0; op_chain = 0; op_src = 0;
    last_op = 0; pending_cnt = 0; chained_cnt = 0; policy = 0; wires_en = 0;
    slots = 16'h1111; cap_hit = 0; chain_map = '0; rel_valid = 0; rel_chain = 0;
  endtask

  // Reference computed from the requirements
  task automatic ref_model();
    int sl[NCL]; bit el[NCL]; bit av[NCL]; int pi[NCL];
    int gi, lf, s0, s1, prod, ch;
    bit split, okp;
    for (int c = 0; c < NCL; c++) begin
      sl[c] = int'(slots[c*4 +: 4]);
      el[c] = (sl[c] != 0) && !cap_hit[c];
      pi[c] = -1;
    end
    lf = 0;
    for (int c = 1; c < NCL; c++) if (sl[c] > sl[lf]) lf = c;
    gi = -1;
    for (int j = 0; j < NCH; j++) begin
      if (m_free[j] && gi < 0) gi = j;
      if (m_free[j] && pi[j % NCL] < 0) pi[j % NCL] = j;
    end
    s0 = int'(op_src[1:0]); s1 = int'(op_src[3:2]);
    if (chained_cnt == 2) begin
      if (s0 == s1) prod = s0;
      else if (el[s0] && el[s1]) prod = (sl[s1] > sl[s0]) ? s1 : s0;
      else if (el[s0]) prod = s0;
      else prod = s1;
    end else if (chained_cnt == 1 || pending_cnt != 0) prod = last_op ? s1 : s0;
    else prod = lf;
    split = wires_en && (policy == 1 || policy == 2);
    for (int c = 0; c < NCL; c++) av[c] = split ? (pi[c] >= 0) : (gi >= 0);
    e_fb = 0; e_stall = 0; e_cl = req_cl;
    if (!wires_en) e_stall = req_head && gi < 0;
    else if (policy == 0) e_stall = !(el[req_cl] && (!req_head || av[req_cl]));
    else begin
      e_cl = 2'(prod);
      okp = el[prod] && (!req_head || av[prod]);
      if (!okp) begin
        if (policy != 2 && lf != prod && el[lf] && av[lf]) begin
          e_fb = 1; e_cl = 2'(lf);
        end else e_stall = 1;
      end
    end
    e_head = req_head | e_fb;
    e_chain = 0;
    if (e_head) e_chain = 5'(split ? pi[e_cl] : gi);
    for (int i = 0; i < 2; i++) begin
      ch = int'(op_chain[i*5 +: 5]);
      e_chd[i] = op_chained[i] && !(e_fb && !chain_map[int'(e_cl)*NCH + ch]);
    end
  endtask

  task automatic compare(input string tag);
    ref_model();
    chk({tag, "/R12 ready"}, 32'(req_ready), 32'(!e_stall));
    chk({tag, " stall"}, 32'(stall), 32'(e_stall));
    if (!e_stall) begin
      chk({tag, " cluster"}, 32'(sel_cl), 32'(e_cl));
      chk({tag, "/R6 head"}, 32'(head_out), 32'(e_head));
      chk({tag, "/R12 chain"}, 32'(sel_chain), 32'(e_chain));
      chk({tag, "/R6 chained"}, 32'(chained_out), 32'(e_chd));
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (req_valid && !e_stall && e_head) m_free[e_chain] = 1'b0;
    if (rel_valid) m_free[rel_chain] = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_free = '1;
  endtask

  // Directed producing-cluster setup: policy 2, no head
  task automatic prod_case(input logic [15:0] sl, input logic [3:0] cap,
                           input logic [1:0] chd, input logic [1:0] pend,
                           input logic [3:0] src, input logic lo);
    idle();
    wires_en = 1; policy = 2; slots = sl; cap_hit = cap;
    op_chained = chd; chained_cnt = 2'(chd[0] + chd[1]); pending_cnt = pend;
    op_chain = {5'd9, 5'd4}; op_src = src; last_op = lo;
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    idle();
    @(negedge clk);
    do_reset();

    // R1: reset state
    req_head = 1; #1;
    chk("R1 chain after reset", 32'(sel_chain), 0);
    chk("R1 ready after reset", 32'(req_ready), 1);

    // R10 / R11: drain the shared pool in order
    for (int i = 0; i < NCH; i++) begin
      req_valid = 1; req_head = 1; #1;
      ref_model();
      chk("R10 drain chain", 32'(sel_chain), 32'(i));
      tick();
    end
    req_valid = 0; #1;
    chk("R10 stall when empty", 32'(stall), 1);
    chk("R12 ready low when empty", 32'(req_ready), 0);
    req_head = 0; #1;
    chk("R10 non-head passes", 32'(stall), 0);
    chk("R12 non-head chain zero", 32'(sel_chain), 0);
    req_head = 1; rel_valid = 1; rel_chain = 5'd7; #1;
    ref_model();
    tick();
    rel_valid = 0; #1;
    chk("R11 released chain reused", 32'(sel_chain), 7);
    req_valid = 1; #1; ref_model(); tick(); req_valid = 0; #1;
    chk("R11 taken again stalls", 32'(stall), 1);

    do_reset();
    // R2: two chains in clusters 1 and 2
    prod_case(16'h0530, 4'h0, 2'b11, 2'd2, 4'b1001, 0);
    chk("R2 more slots wins", 32'(sel_cl), 2);
    prod_case(16'h0440, 4'h0, 2'b11, 2'd2, 4'b1001, 0);
    chk("R2 tie keeps first", 32'(sel_cl), 1);
    prod_case(16'h0530, 4'h2, 2'b11, 2'd2, 4'b1001, 0);
    chk("R2 only second eligible", 32'(sel_cl), 2);
    prod_case(16'h0000, 4'h0, 2'b11, 2'd2, 4'b1001, 0);
    chk("R2 neither eligible stalls", 32'(stall), 1);
    // R3
    prod_case(16'h1111, 4'h0, 2'b01, 2'd1, 4'b0011, 0);
    chk("R3 last op source", 32'(sel_cl), 3);
    prod_case(16'h1772, 4'h0, 2'b00, 2'd0, 4'b0000, 0);
    chk("R3 least full tie low", 32'(sel_cl), 1);

    // Random sweep over all policies: R4 R5 R6 R7 R8 R9
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      int extra, rid;
      string tag;
      idle();
      r = rnd();
      policy = r[1:0];
      wires_en = (r[4:2] != 0);
      req_head = r[5];
      req_cl = r[7:6];
      op_chained = r[9:8];
      chained_cnt = 2'(op_chained[0] + op_chained[1]);
      extra = int'(r[11:10]) % (3 - int'(chained_cnt));
      pending_cnt = 2'(int'(chained_cnt) + extra);
      op_src = r[15:12];
      last_op = r[16];
      req_valid = r[17] | r[18];
      r = rnd();
      op_chain = r[9:0];
      if (op_chain[4:0] == op_chain[9:5]) op_chain[5] = ~op_chain[5];
      for (int c = 0; c < NCL; c++) begin
        logic [7:0] q;
        q = rnd()[7:0];
        slots[c*4 +: 4] = (q[1:0] == 0) ? 4'd0 : q[7:4];
        cap_hit[c] = (q[3:2] == 0);
      end
      chain_map = {rnd(), rnd(), rnd(), rnd()};
      r = rnd();
      rid = int'(r[4:0]);
      if (!m_free[rid] && r[5]) begin
        rel_valid = 1; rel_chain = 5'(rid);
      end
      #1;
      if (!wires_en) tag = "R10";
      else case (policy)
        2'd0: tag = "R4/R9";
        2'd1: tag = "R5/R6/R9";
        2'd2: tag = "R7/R9";
        default: tag = "R8/R6/R9";
      endcase
      compare(tag);
      tick();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule